// File: doc/BRIEF.md
# UART Interrupt and FIFO-Level Controller

This block generates the interrupt request for a UART whose transmit and receive queues each hold 32 characters. The queue storage, the serial shifter and the baud generator are outside the block. They report to it the current fill counts of both queues, a strobe for each character received, a strobe for each character the host takes, a one-cycle tick per bit period, the clear-to-send input and line-error strobes. From these inputs the block forms eight raw status bits.

Software reaches the block through a small synchronous register port. Writes take effect at the clock edge and reads are combinational. The register map is: address 0 control (bit 0 turns both queues on), address 1 trigger select (bits [2:0] receive code, bits [5:3] transmit code), address 2 enable mask, address 3 raw status (read only), address 4 masked status (read only), address 5 clear (write only, reads 0), address 6 line flags (bit 0 is the present clear-to-send level).

Status bit positions are the same in raw, mask, masked and clear: bit 0 receive, bit 1 transmit, bit 2 receive timeout, bit 3 modem status, bit 4 framing error, bit 5 parity error, bit 6 break, bit 7 overrun. A single `irq` output is driven high while any enabled bit is pending.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, control reads 0, trigger select reads 0x12 (both codes 2), mask reads 0 and `irq` and `fifo_en` are low. Raw status is 0 when `rx_level` is 0 and `tx_level` is nonzero.
- R2: The mask register reads back what was written. A 1 in a mask bit enables that source and a 0 disables it. `irq` is high exactly when at least one bit is set in both the raw status and the mask, so an all-zero mask keeps `irq` low.
- R3: Raw status and masked status are separate registers. Masked status reads as raw AND mask.
- R4: Writing 1 to a clear bit drops that raw bit at the next edge unless its source is still active in that cycle. Writing 0 leaves the bit unchanged. The clear address reads 0.
- R5: Raw bit 0 is set in every cycle where `rx_level` is at or above the receive threshold. A clear does not hold while that condition is true.
- R6: Raw bit 1 is set in every cycle where `tx_level` is at or below the transmit threshold.
- R7: With the queues on, trigger codes 0, 1, 2, 3 and 4 give thresholds of 4, 8, 16, 24 and 28 characters. Codes 5 to 7 act as code 2.
- R8: With control bit 0 clear, each queue is a one-character holding register. The receive threshold is then 1 and the transmit threshold is 0. `fifo_en` follows control bit 0.
- R9: Raw bit 2 is set once 32 bit ticks have arrived while the receive queue is non-empty and there has been no receive strobe and no read strobe. It keeps being set until the count is restarted.
- R10: A receive strobe or a read strobe restarts the timeout count. An empty receive queue holds the count at zero.
- R11: A change of `cts_in` in either direction sets raw bit 3. Flags bit 0 reads the present `cts_in` level.
- R12: A pulse on `err_in[j]` sets raw bit 4+j. That bit stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tx_level | input | 6 | Transmit queue fill count, 0 to 32 |
| rx_level | input | 6 | Receive queue fill count, 0 to 32 |
| rx_push | input | 1 | A character entered the receive queue |
| rx_pop | input | 1 | The host read a character from the receive queue |
| bit_tick | input | 1 | One pulse per bit period |
| cts_in | input | 1 | Clear-to-send level |
| err_in | input | 4 | Framing, parity, break and overrun strobes |
| fifo_en | output | 1 | Queues enabled (control bit 0) |
| irq | output | 1 | OR of all masked status bits |

## Verification
The trigger logic is tested with fill counts one step short of each code's threshold and then exactly at it, for both directions and all eight codes. This separates the correct thresholds from off-by-one and inverted comparisons, and it also exposes a wrong mapping of the reserved codes. The timeout is tested with 31 and then 32 ticks, with a restart by a receive strobe and by a read strobe, and with an empty queue. These cases tell a correct count limit apart from a count that never restarts or that runs while the queue is empty. The mask and clear tests set level-driven and event-driven sources at the same time. This shows whether a clear sticks only for sources that are no longer active, and whether a zero write changes anything.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int DEPTH   = 32,
  parameter int TO_BITS = 32,
  parameter int AW      = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [AW-1:0]                 reg_addr,
  input  logic [7:0]                    reg_wdata,
  output logic [7:0]                    reg_rdata,
  input  logic [$clog2(DEPTH+1)-1:0]    tx_level,
  input  logic [$clog2(DEPTH+1)-1:0]    rx_level,
  input  logic                          rx_push,
  input  logic                          rx_pop,
  input  logic                          bit_tick,
  input  logic                          cts_in,
  input  logic [3:0]                    err_in,
  output logic                          fifo_en,
  output logic                          irq
);
  localparam int LW = $clog2(DEPTH+1);
  localparam int CW = $clog2(TO_BITS+1);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_LVL  = AW'(1);
  localparam logic [AW-1:0] A_MASK = AW'(2);
  localparam logic [AW-1:0] A_RAW  = AW'(3);
  localparam logic [AW-1:0] A_MIS  = AW'(4);
  localparam logic [AW-1:0] A_CLR  = AW'(5);
  localparam logic [AW-1:0] A_FLAG = AW'(6);

  logic          fifo_en_q;
  logic [5:0]    lvl_q;
  logic [7:0]    mask_q;
  logic [7:0]    raw_q;
  logic          cts_q;
  logic [CW-1:0] to_cnt;

  function automatic logic [LW-1:0] thr_of(input logic [2:0] code);
    case (code)
      3'd0:    thr_of = LW'(DEPTH / 8);
      3'd1:    thr_of = LW'(DEPTH / 4);
      3'd3:    thr_of = LW'(DEPTH * 3 / 4);
      3'd4:    thr_of = LW'(DEPTH * 7 / 8);
      default: thr_of = LW'(DEPTH / 2);
    endcase
  endfunction

  wire [LW-1:0] rx_thr = fifo_en_q ? thr_of(lvl_q[2:0]) : LW'(1);
  wire [LW-1:0] tx_thr = fifo_en_q ? thr_of(lvl_q[5:3]) : '0;
  wire          timed_out = (to_cnt == CW'(TO_BITS));
  wire [7:0]    clr = (reg_we && reg_addr == A_CLR) ? reg_wdata : 8'h00;
  wire [7:0]    set = {err_in, (cts_in != cts_q), timed_out,
                       (tx_level <= tx_thr), (rx_level >= rx_thr)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_en_q <= 1'b0;
      lvl_q     <= 6'b010_010;
      mask_q    <= '0;
      raw_q     <= '0;
      cts_q     <= 1'b0;
      to_cnt    <= '0;
    end else begin
      if (reg_we && reg_addr == A_CTRL) fifo_en_q <= reg_wdata[0];
      if (reg_we && reg_addr == A_LVL)  lvl_q     <= reg_wdata[5:0];
      if (reg_we && reg_addr == A_MASK) mask_q    <= reg_wdata;
      raw_q <= set | (raw_q & ~clr);
      cts_q <= cts_in;
      if (rx_level == '0 || rx_push || rx_pop) to_cnt <= '0;
      else if (bit_tick && !timed_out)         to_cnt <= to_cnt + 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {7'b0, fifo_en_q};
      A_LVL:   reg_rdata = {2'b0, lvl_q};
      A_MASK:  reg_rdata = mask_q;
      A_RAW:   reg_rdata = raw_q;
      A_MIS:   reg_rdata = raw_q & mask_q;
      A_FLAG:  reg_rdata = {7'b0, cts_in};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign fifo_en = fifo_en_q;
  assign irq     = |(raw_q & mask_q);
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int DEPTH   = 32,
  parameter int TO_BITS = 32,
  parameter int AW      = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_we,
  input logic [AW-1:0]              reg_addr,
  input logic [7:0]                 reg_wdata,
  input logic [$clog2(DEPTH+1)-1:0] rx_level,
  input logic [3:0]                 err_in,
  input logic                       cts_in,
  input logic                       cts_q,
  input logic                       fifo_en_q,
  input logic [7:0]                 raw_q,
  input logic [7:0]                 mask_q,
  input logic [$clog2(TO_BITS+1)-1:0] to_cnt,
  input logic                       irq
);
  // R2
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'h00) |-> !irq);
  // R12
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_in != 4'h0) |=> ((raw_q[7:4] & $past(err_in)) == $past(err_in)));
  // R11
  cts_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_in != cts_q) |=> raw_q[3]);
  // R5
  rx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_q && int'(rx_level) >= DEPTH * 7 / 8) |=> raw_q[0]);
  // R10
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |=> (to_cnt == '0));
  // R4
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(5) && reg_wdata == 8'h00) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.DEPTH(DEPTH), .TO_BITS(TO_BITS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .rx_level(rx_level), .err_in(err_in), .cts_in(cts_in), .cts_q(cts_q),
  .fifo_en_q(fifo_en_q), .raw_q(raw_q), .mask_q(mask_q), .to_cnt(to_cnt), .irq(irq)
);

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [5:0] tx_level = 6'd1;
  logic [5:0] rx_level = 6'd0;
  logic       rx_push = 0, rx_pop = 0, bit_tick = 0, cts_in = 0;
  logic [3:0] err_in = 0;
  logic       fifo_en, irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_level(tx_level), .rx_level(rx_level), .rx_push(rx_push),
    .rx_pop(rx_pop), .bit_tick(bit_tick), .cts_in(cts_in), .err_in(err_in),
    .fifo_en(fifo_en), .irq(irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1;
      @(negedge clk); bit_tick = 0;
    end
  endtask

  function automatic int thr_exp(input int code);
    case (code)
      0: return 4; 1: return 8; 3: return 24; 4: return 28;
      default: return 16;
    endcase
  endfunction

  task automatic t_reset;
    logic [7:0] v;
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 level select", v, 8'h12);
    rd(3'd2, v); chk("R1 mask", v, 0);
    rd(3'd3, v); chk("R1 raw", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 fifo_en", fifo_en, 0);
  endtask

  task automatic t_holding;
    logic [7:0] v;
    rx_level = 1; step(1);
    rd(3'd3, v); chk("R8 rx holding", v, 8'h01);
    tx_level = 0; step(1);
    rd(3'd3, v); chk("R8 tx holding", v, 8'h03);
    rx_level = 0; tx_level = 1;
    wr(3'd5, 8'h03);
    rd(3'd3, v); chk("R8 cleared", v, 0);
  endtask

  task automatic t_levels;
    logic [7:0] v;
    wr(3'd0, 8'h01);
    chk("R8 fifo_en", fifo_en, 1);
    for (int code = 0; code < 8; code++) begin
      int t = thr_exp(code);
      wr(3'd1, 8'((code << 3) | code));
      rx_level = 6'(t - 1); tx_level = 6'(t + 1);
      wr(3'd5, 8'h03);
      rd(3'd3, v); chk($sformatf("R7 code %0d below", code), int'(v[1:0]), 0);
      rx_level = 6'(t); step(1);
      rd(3'd3, v); chk($sformatf("R5 rx at threshold code %0d", code), int'(v[0]), 1);
      tx_level = 6'(t); step(1);
      rd(3'd3, v); chk($sformatf("R6 tx at threshold code %0d", code), int'(v[1]), 1);
      wr(3'd5, 8'h01);
      rd(3'd3, v); chk($sformatf("R5 clear while active code %0d", code), int'(v[0]), 1);
    end
    rx_level = 0; tx_level = 31;
    wr(3'd1, 8'h12);
    wr(3'd5, 8'hFF);
    rd(3'd3, v); chk("R4 clear all", v, 0);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    rx_level = 32;
    @(negedge clk); err_in = 4'h1;
    @(negedge clk); err_in = 4'h0;
    rd(3'd3, v); chk("R3 raw", v, 8'h11);
    chk("R2 irq off with zero mask", irq, 0);
    wr(3'd2, 8'h10);
    rd(3'd4, v); chk("R3 masked", v, 8'h10);
    chk("R2 irq on", irq, 1);
    wr(3'd2, 8'h02);
    rd(3'd2, v); chk("R2 mask readback", v, 8'h02);
    rd(3'd4, v); chk("R3 masked none", v, 0);
    chk("R2 irq off", irq, 0);
  endtask

  task automatic t_clear;
    logic [7:0] v;
    wr(3'd5, 8'h00);
    rd(3'd3, v); chk("R4 zero write", v, 8'h11);
    wr(3'd5, 8'h10);
    rd(3'd3, v); chk("R4 one write", v, 8'h01);
    rd(3'd5, v); chk("R4 clear reads zero", v, 0);
    rx_level = 0;
    wr(3'd5, 8'h01);
    rd(3'd3, v); chk("R4 rx dropped", v, 0);
  endtask

  task automatic t_errors;
    logic [7:0] v;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk); err_in = 4'(1 << j);
      @(negedge clk); err_in = 0;
      step(2);
      rd(3'd3, v); chk($sformatf("R12 error %0d", j), v, 1 << (4 + j));
      wr(3'd5, 8'(1 << (4 + j)));
    end
  endtask

  task automatic t_cts;
    logic [7:0] v;
    @(negedge clk); cts_in = 1;
    step(1);
    rd(3'd3, v); chk("R11 rise", int'(v[3]), 1);
    rd(3'd6, v); chk("R11 flag high", v, 1);
    wr(3'd5, 8'h08);
    rd(3'd3, v); chk("R11 cleared", int'(v[3]), 0);
    @(negedge clk); cts_in = 0;
    step(1);
    rd(3'd3, v); chk("R11 fall", int'(v[3]), 1);
    rd(3'd6, v); chk("R11 flag low", v, 0);
    wr(3'd5, 8'h08);
  endtask

  task automatic t_timeout;
    logic [7:0] v;
    rx_level = 2;
    @(negedge clk); rx_push = 1;
    @(negedge clk); rx_push = 0;
    ticks(31); step(1);
    rd(3'd3, v); chk("R9 31 ticks", int'(v[2]), 0);
    ticks(1); step(1);
    rd(3'd3, v); chk("R9 32 ticks", int'(v[2]), 1);
    wr(3'd5, 8'h04);
    rd(3'd3, v); chk("R9 clear while timed out", int'(v[2]), 1);
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
    wr(3'd5, 8'h04);
    ticks(31); step(1);
    rd(3'd3, v); chk("R10 read restarts", int'(v[2]), 0);
    @(negedge clk); rx_push = 1;
    @(negedge clk); rx_push = 0;
    ticks(31); step(1);
    rd(3'd3, v); chk("R10 receive restarts", int'(v[2]), 0);
    ticks(1); step(1);
    rd(3'd3, v); chk("R10 after restart", int'(v[2]), 1);
    rx_level = 0; step(1);
    wr(3'd5, 8'h04);
    ticks(40); step(1);
    rd(3'd3, v); chk("R10 empty", int'(v[2]), 0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset;
    t_holding;
    t_levels;
    t_mask;
    t_clear;
    t_errors;
    t_cts;
    t_timeout;
    summary;
  end

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary;
  end
endmodule